// File: doc/BRIEF.md
# Retransmit-Capable First-In First-Out Buffer

This block is a single-clock first-in first-out buffer for 9-bit words, which is enough for a byte plus its parity bit. The depth is a parameter and may be 512 or 1024 words. The caller never supplies an address. A write pointer and a read pointer each advance by one on their own accepted strobe and wrap from the last location back to zero. Push and pop are independent requests and may be raised in the same cycle.

Occupancy is tracked by a four-state machine: `OCC_EMPTY`, `OCC_LOW` (fewer than half the words), `OCC_HIGH` (at least half, not full) and `OCC_FULL`. The next state comes only from the next occupancy level. The machine goes to `OCC_EMPTY` when the level becomes zero, to `OCC_FULL` when it reaches the depth, to `OCC_HIGH` when it is at or above half the depth, and to `OCC_LOW` otherwise. Any state can reach any other in one step through retransmit. Through push and pop alone, the only steps are to a neighbouring state or staying in place.

A rewind input sends the read pointer back to location zero and leaves the write pointer alone. Everything written since reset can then be read out again. This is useful when a receiver reports a corrupted transfer. Rewind is only meaningful while fewer words than the depth have been written since reset.

Top module: `rtx_fifo`

## Requirements
- R1: A synchronous reset clears both pointers and the occupancy. After it `is_empty`=1, `is_full`=0, `is_half`=0 and `pop_data`=0.
- R2: Words are read out in the order they were written. Addresses come only from the internal pointers.
- R3: A push while `is_full`=1 is ignored and overwrites no stored word.
- R4: A pop while `is_empty`=1 is ignored: the read pointer and `pop_data` keep their values.
- R5: A push and a pop in the same cycle, while neither full nor empty, both take effect and leave the occupancy and flags unchanged.
- R6: A push and a pop in the same cycle while empty perform only the push. `is_empty` then drops and `pop_data` keeps its value.
- R7: `is_half`=1 exactly when the occupancy is at least DEPTH/2.
- R8: `is_full`=1 exactly when the occupancy equals DEPTH, and `is_empty`=1 exactly when it is zero.
- R9: `rewind`=1 sets the read pointer to zero and leaves the write pointer unchanged. The occupancy becomes the write pointer plus any push accepted in that cycle. A pop requested in the same cycle is ignored.
- R10: Both pointers wrap from DEPTH-1 to 0, and data stays in order across the wrap.
- R11: `pop_data` is registered. It takes the oldest word on the clock edge that accepts a pop and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Write request |
| push_data | input | 9 | Word to write |
| pop | input | 1 | Read request |
| rewind | input | 1 | Send read pointer back to location zero |
| pop_data | output | 9 | Last word read, registered |
| is_empty | output | 1 | No words held |
| is_full | output | 1 | DEPTH words held |
| is_half | output | 1 | At least DEPTH/2 words held |

## Verification
The assertions assume that `rewind` is only raised while fewer than DEPTH words have been written since the last reset. Past that point the write pointer no longer equals the number of words written. The stimulus keeps to this by issuing rewinds only in a short sequence directly after a reset. The fill, wrap and random phases never raise `rewind`. No other input constraint is needed: pushes while full and pops while empty are legal and are exercised on purpose.

// File: rtl/rtx_fifo_pkg.sv
package rtx_fifo_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_LOW   = 2'd1,
        OCC_HIGH  = 2'd2,
        OCC_FULL  = 2'd3
    } occ_state_e;

endpackage

// File: rtl/rtx_fifo_ptr.sv
module rtx_fifo_ptr #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          to_zero,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

    logic [AW-1:0] ptr_inc;

    generate
        if (POW2) begin : g_natural_wrap
            assign ptr_inc = ptr + AW'(1);
        end else begin : g_compare_wrap
            assign ptr_inc = (ptr == LAST) ? '0 : ptr + AW'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (to_zero) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= ptr_inc;
        end
    end

    // R10: last location steps to zero
    p_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        (ptr == LAST && adv && !to_zero) |=> (ptr == '0));

    // R9: a rewind lands on zero
    p_rewind_r9: assert property (@(posedge clk) disable iff (rst)
        to_zero |=> (ptr == '0));

    // R2: pointer moves only on request
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!adv && !to_zero) |=> $stable(ptr));

endmodule

// File: rtl/rtx_fifo_mem.sv
module rtx_fifo_mem #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= cells[raddr];
        end
    end

    // R11: output register holds unless a read is accepted
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !re |=> $stable(rdata));

endmodule

// File: rtl/rtx_fifo_ctrl.sv
module rtx_fifo_ctrl
    import rtx_fifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          rewind,
    input  logic [AW-1:0] wr_ptr,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic          is_empty,
    output logic          is_full,
    output logic          is_half
);

    localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] LVL_HALF = CW'(DEPTH / 2);

    occ_state_e    st_q, st_d;
    logic [CW-1:0] lvl_q, lvl_d;

    always_comb begin
        wr_ok = push && (st_q != OCC_FULL);
        rd_ok = pop && !rewind && (st_q != OCC_EMPTY);
    end

    always_comb begin
        if (rewind) begin
            lvl_d = CW'(wr_ptr) + CW'(wr_ok);
        end else begin
            lvl_d = lvl_q + CW'(wr_ok) - CW'(rd_ok);
        end
    end

    always_comb begin
        if (lvl_d == '0) begin
            st_d = OCC_EMPTY;
        end else if (lvl_d == LVL_FULL) begin
            st_d = OCC_FULL;
        end else if (lvl_d >= LVL_HALF) begin
            st_d = OCC_HIGH;
        end else begin
            st_d = OCC_LOW;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= OCC_EMPTY;
            lvl_q <= '0;
        end else begin
            st_q  <= st_d;
            lvl_q <= lvl_d;
        end
    end

    always_comb begin
        is_empty = 1'b0;
        is_full  = 1'b0;
        is_half  = 1'b0;
        unique case (st_q)
            OCC_EMPTY: is_empty = 1'b1;
            OCC_LOW:   ;
            OCC_HIGH:  is_half = 1'b1;
            OCC_FULL: begin
                is_full = 1'b1;
                is_half = 1'b1;
            end
            default:   ;
        endcase
    end

    // R3: level never exceeds depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        lvl_q <= LVL_FULL);

    // R3: a lone push while full leaves it full
    p_full_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (is_full && push && !pop && !rewind) |=> is_full);

    // R4: a lone pop while empty leaves it empty
    p_empty_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (is_empty && pop && !push && !rewind) |=> is_empty);

    // R5: paired push and pop keep the level
    p_pair_level_r5: assert property (@(posedge clk) disable iff (rst)
        (!is_full && !is_empty && push && pop && !rewind) |=> $stable(lvl_q));

    // R8: flags exclusive
    p_flag_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(is_full && is_empty));

    // R7: half flag tracks the level
    p_half_level_r7: assert property (@(posedge clk) disable iff (rst)
        is_half == (lvl_q >= LVL_HALF));

endmodule

// File: rtl/rtx_fifo.sv
module rtx_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    input  logic             rewind,
    output logic [WIDTH-1:0] pop_data,
    output logic             is_empty,
    output logic             is_full,
    output logic             is_half
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          wr_ok, rd_ok;
    logic [AW-1:0] wr_ptr, rd_ptr;

    rtx_fifo_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (pop),
        .rewind   (rewind),
        .wr_ptr   (wr_ptr),
        .wr_ok    (wr_ok),
        .rd_ok    (rd_ok),
        .is_empty (is_empty),
        .is_full  (is_full),
        .is_half  (is_half)
    );

    rtx_fifo_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
        .clk     (clk),
        .rst     (rst),
        .adv     (wr_ok),
        .to_zero (1'b0),
        .ptr     (wr_ptr)
    );

    rtx_fifo_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
        .clk     (clk),
        .rst     (rst),
        .adv     (rd_ok),
        .to_zero (rewind),
        .ptr     (rd_ptr)
    );

    rtx_fifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_ok),
        .waddr (wr_ptr),
        .wdata (push_data),
        .re    (rd_ok),
        .raddr (rd_ptr),
        .rdata (pop_data)
    );

    // R11: data out moves only on an accepted pop
    p_dout_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!pop || is_empty || rewind) |=> $stable(pop_data));

    // R6: paired push and pop while empty leaves data and fills one word
    p_empty_pair_r6: assert property (@(posedge clk) disable iff (rst)
        (is_empty && push && pop && !rewind) |=> (!is_empty && $stable(pop_data)));

    // R9: rewind does not move the write pointer
    p_rewind_wptr_r9: assert property (@(posedge clk) disable iff (rst)
        (rewind && !push) |=> $stable(wr_ptr));

endmodule

// File: tb/rtx_fifo_tb_top.sv
module rtx_fifo_tb_top;

    localparam int W = 9;
    localparam int D = 512;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         push = 1'b0;
    logic [W-1:0] push_data = '0;
    logic         pop = 1'b0;
    logic         rewind = 1'b0;
    logic [W-1:0] pop_data;
    logic         is_empty, is_full, is_half;

    always #2 clk = ~clk;

    rtx_fifo #(.WIDTH(W), .DEPTH(D)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .rewind    (rewind),
        .pop_data  (pop_data),
        .is_empty  (is_empty),
        .is_full   (is_full),
        .is_half   (is_half)
    );

    logic [W-1:0] pend[$];
    logic [W-1:0] hist[$];
    bit           hist_ok;
    logic [W-1:0] m_out;
    int           n_vec = 0;
    int           n_bad = 0;

    task automatic chk(input string tag, input string nm, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "is_empty", int'(is_empty), int'(pend.size() == 0));
        chk(tag, "is_full",  int'(is_full),  int'(pend.size() == D));
        chk(tag, "is_half",  int'(is_half),  int'(pend.size() >= D / 2));
        chk(tag, "pop_data", int'(pop_data), int'(m_out));
    endtask

    // one cycle: drive at negedge, update the model at posedge, compare at next negedge
    task automatic cyc(input bit w, input logic [W-1:0] d, input bit r, input bit x,
                       input string tag);
        bit acc_w;
        push = w; push_data = d; pop = r; rewind = x;
        @(posedge clk);
        acc_w = w && (pend.size() < D);
        if (x) begin
            pend = hist;
        end else if (r && pend.size() > 0) begin
            m_out = pend.pop_front();
        end
        if (acc_w) begin
            pend.push_back(d);
            if (hist_ok) begin
                if (hist.size() < D) hist.push_back(d);
                else hist_ok = 1'b0;
            end
        end
        @(negedge clk);
        push = 1'b0; pop = 1'b0; rewind = 1'b0;
        check_all(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        pend.delete();
        hist.delete();
        hist_ok = 1'b1;
        m_out = '0;
        check_all("R1");
    endtask

    function automatic logic [W-1:0] val(input int i);
        return W'(i * 37 + 11);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();                                   // R1
        for (int i = 0; i < 3; i++) cyc(0, '0, 1, 0, "R4");   // R4 pop while empty
        for (int i = 0; i < 6; i++) cyc(1, val(i), 0, 0, "R2");
        for (int i = 0; i < 6; i++) cyc(0, '0, 1, 0, "R11");  // R2 order, R11 timing
        cyc(1, val(100), 1, 0, "R6");                         // R6 pair while empty
        for (int i = 0; i < 5; i++) cyc(1, val(200 + i), 1, 0, "R5");
        while (pend.size() > 0) cyc(0, '0, 1, 0, "R2");
        for (int i = 0; i < D; i++) cyc(1, val(300 + i), 0, 0, "R7"); // R7, R8 fill
        for (int i = 0; i < 4; i++) cyc(1, val(900 + i), 0, 0, "R3"); // R3 push while full
        cyc(1, val(950), 1, 0, "R8");                                  // R8 full: pop only
        while (pend.size() > 0) cyc(0, '0, 1, 0, "R3");                // R3 no overwrite
        for (int i = 0; i < 40; i++) cyc(1, val(1000 + i), 0, 0, "R10");
        while (pend.size() > 0) cyc(0, '0, 1, 0, "R10");

        do_reset();
        for (int i = 0; i < 10; i++) cyc(1, val(2000 + i), 0, 0, "R9");
        for (int i = 0; i < 4; i++) cyc(0, '0, 1, 0, "R9");
        cyc(0, '0, 0, 1, "R9");                               // R9 rewind
        for (int i = 0; i < 10; i++) cyc(0, '0, 1, 0, "R9");
        cyc(1, val(2100), 1, 1, "R9");                        // R9 rewind with push and pop
        while (pend.size() > 0) cyc(0, '0, 1, 0, "R9");

        do_reset();
        for (int i = 0; i < 4000; i++) begin                  // R10 R5 random mix
            int pw;
            pw = ((i / 600) % 2 == 0) ? 75 : 30;
            cyc(($urandom % 100) < pw, W'($urandom), ($urandom % 100) < 50, 0, "R10");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule